// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block decides which pending event a processor core enters and works out every architectural register update that goes with that entry. The events are an external interrupt, a hardware break, a memory-translation fault and other hardware exceptions. For one cycle it reads the current program counter, status word, instruction-state flags (delay slot, immediate prefix, prefixed branch), the pending branch target and the vector base. From these it produces the handler address, the link register to write and its value, the new status word, the syndrome and fault-address values, the branch-target save, and strobes that clear the instruction-state flags and the load reservation.

Events that arrive together are ranked. A translation fault comes first, then any other hardware exception, then a break, then an external interrupt. An external interrupt is held back while interrupts are masked, while an exception or break handler is already running, and while the current instruction sits in a delay slot or follows an immediate prefix. The link value for a translation fault points back to the branch or prefix that must run again. All results are registered and appear together with a single commit strobe one cycle after the request is sampled.

Top module: `exc_entry`

## Requirements
- R1: The handler address is `vec_base` + 0x10 for an external interrupt, + 0x18 for a break, and + 0x20 for a hardware exception or a translation fault.
- R2: An external interrupt writes `cur_pc` to link register 14 and clears the interrupt-enable bit (status bit 0).
- R3: A break writes `cur_pc` to link register 16 and sets the break-active bit (status bit 1).
- R4: A hardware exception writes `cur_pc`+4 to link register 17, sets the exception-active bit (status bit 2) and writes `hwx_syn` to the syndrome, with bit 12 replaced by the delay-slot flag.
- R5: A translation fault writes link register 17 and sets status bit 2. The link value is `cur_pc`−8 when in a delay slot with the prefixed-branch flag set, `cur_pc`−4 when in a delay slot without it, `cur_pc`−4 when only the immediate-prefix flag is set, and `cur_pc` otherwise.
- R6: On a fault or hardware exception, syndrome bit 12 equals the delay-slot flag. When that flag is set, `br_target` is written to the branch-target register (`btr_we`=1); when it is clear, that register is not written.
- R7: On every entry the status word gets bit 5 = old bit 4 (user mode) and bit 7 = old bit 6 (translation on), while bits 4 and 6 are cleared. All other bits keep their values apart from the per-event change.
- R8: The translation-fault syndrome code in bits 4:0 is 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss (`mmu_miss`=1 marks a miss; `mmu_acc` 0 = fetch, 1 = load, 2 = store, 3 = load). Bit 10 is set for a store. `mmu_addr` is written to the fault-address register.
- R9: An external interrupt is taken only when status bit 0 is set, status bits 1 and 2 are both clear, and neither `in_dslot` nor `in_imm` is set.
- R10: When `exc_support` is 0, a hardware-exception request is ignored: it produces no commit, and a lower-ranked event pending in the same cycle is taken instead.
- R11: Every entry asserts `iflag_clr` and `resv_clr` for the commit cycle.
- R12: Ranking is translation fault, then hardware exception, then break, then external interrupt. Exactly one entry is made per cycle.
- R13: Results appear one clock after the request is sampled. `commit` and `busy` are high together for exactly that cycle. With no accepted request, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | External interrupt pending |
| brk_req | input | 1 | Hardware break pending |
| mmu_req | input | 1 | Translation fault pending |
| mmu_miss | input | 1 | 1 = miss, 0 = protection fault |
| mmu_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store, 3 load |
| mmu_addr | input | AW | Faulting address |
| hwx_req | input | 1 | Other hardware exception pending |
| hwx_syn | input | ESR_W | Syndrome supplied with the hardware exception |
| exc_support | input | 1 | Hardware exceptions configured in |
| cur_pc | input | AW | Current program counter |
| cur_stat | input | STAT_W | Current status word |
| in_dslot | input | 1 | Current instruction is in a delay slot |
| in_imm | input | 1 | Current instruction follows an immediate prefix |
| in_bimm | input | 1 | The branch owning the delay slot used a prefix |
| br_target | input | AW | Pending branch target |
| vec_base | input | AW | Vector table base |
| commit | output | 1 | Entry valid; all writes below apply |
| busy | output | 1 | High during the commit cycle |
| new_pc | output | AW | Handler address |
| link_we | output | 1 | Link register write |
| link_sel | output | 5 | Link register number |
| link_val | output | AW | Link value |
| stat_val | output | STAT_W | New status word |
| esr_we | output | 1 | Syndrome write |
| esr_val | output | ESR_W | Syndrome value |
| ear_we | output | 1 | Fault-address write |
| ear_val | output | AW | Fault address |
| btr_we | output | 1 | Branch-target register write |
| btr_val | output | AW | Saved branch target |
| iflag_clr | output | 1 | Clear instruction-state flags |
| resv_clr | output | 1 | Invalidate load reservation |

## Verification
Each result passes through one register, so a request applied before a rising edge shows on every output port just after that edge and falls back to zero one edge later unless a new request is applied. The bench drives each cycle's inputs at the falling edge, lets one rising edge pass, and samples 1 ns later. At that point it compares every output port against a reference model evaluated on the same inputs. Idle cycles are compared the same way, so a late or lingering strobe is counted as a mismatch.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   // request ranking, index 0 is strongest
   localparam int NEV   = 4;
   localparam int G_MMU = 0;
   localparam int G_HWX = 1;
   localparam int G_BRK = 2;
   localparam int G_IRQ = 3;

   // status word bit positions
   localparam int ST_IE  = 0;
   localparam int ST_BIP = 1;
   localparam int ST_EIP = 2;
   localparam int ST_UM  = 4;
   localparam int ST_UMS = 5;
   localparam int ST_VM  = 6;
   localparam int ST_VMS = 7;

   // syndrome layout
   localparam int SY_CODE_W = 5;
   localparam int SY_STORE  = 10;
   localparam int SY_DSLOT  = 12;

   localparam logic [4:0] LR_IRQ = 5'd14;
   localparam logic [4:0] LR_BRK = 5'd16;
   localparam logic [4:0] LR_EXC = 5'd17;

   localparam logic [SY_CODE_W-1:0] SC_PROT = 5'd16;
   localparam logic [SY_CODE_W-1:0] SC_MISS = 5'd18;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;
endpackage

// File: rtl/exc_arb.sv
module exc_arb
   import exc_entry_pkg::*;
#(
   parameter int N = NEV
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N-1:0] shadow;

   assign shadow[0] = 1'b0;
   for (genvar i = 1; i < N; i++) begin : g_chain
      assign shadow[i] = shadow[i-1] | req[i-1];
   end

   assign grant = req & ~shadow;
endmodule

// File: rtl/exc_link.sv
module exc_link
   import exc_entry_pkg::*;
#(
   parameter int AW      = 32,
   parameter int OFS_IRQ = 'h10,
   parameter int OFS_BRK = 'h18,
   parameter int OFS_EXC = 'h20
) (
   input  logic [NEV-1:0] grant,
   input  logic [AW-1:0]  pc,
   input  logic [AW-1:0]  vec_base,
   input  logic           dslot,
   input  logic           imm,
   input  logic           bimm,
   output logic [AW-1:0]  target,
   output logic [4:0]     lsel,
   output logic [AW-1:0]  lval
);
   localparam logic [AW-1:0] K_IRQ = AW'(OFS_IRQ);
   localparam logic [AW-1:0] K_BRK = AW'(OFS_BRK);
   localparam logic [AW-1:0] K_EXC = AW'(OFS_EXC);
   localparam logic [AW-1:0] STEP  = AW'(4);

   logic [AW-1:0] replay;

   // how far back the faulting fetch must restart
   always_comb begin
      if (dslot)
         replay = bimm ? pc - (STEP << 1) : pc - STEP;
      else if (imm)
         replay = pc - STEP;
      else
         replay = pc;
   end

   always_comb begin
      target = '0;
      lsel   = '0;
      lval   = '0;
      unique case (1'b1)
         grant[G_MMU]: begin
            target = vec_base + K_EXC;
            lsel   = LR_EXC;
            lval   = replay;
         end
         grant[G_HWX]: begin
            target = vec_base + K_EXC;
            lsel   = LR_EXC;
            lval   = pc + STEP;
         end
         grant[G_BRK]: begin
            target = vec_base + K_BRK;
            lsel   = LR_BRK;
            lval   = pc;
         end
         grant[G_IRQ]: begin
            target = vec_base + K_IRQ;
            lsel   = LR_IRQ;
            lval   = pc;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
   import exc_entry_pkg::*;
#(
   parameter int ESR_W = 16
) (
   input  logic [NEV-1:0]   grant,
   input  logic             miss,
   input  logic [1:0]       acc,
   input  logic [ESR_W-1:0] hwx_syn,
   input  logic             dslot,
   output logic             we,
   output logic [ESR_W-1:0] val,
   output logic             save_tgt
);
   logic [SY_CODE_W-1:0] code;
   logic                 is_fetch;
   logic                 is_store;

   assign is_fetch = (acc_e'(acc) == ACC_FETCH);
   assign is_store = (acc_e'(acc) == ACC_STORE);
   assign code     = (miss ? SC_MISS : SC_PROT) | {{(SY_CODE_W-1){1'b0}}, is_fetch};

   always_comb begin
      val = '0;
      if (grant[G_MMU]) begin
         val[SY_CODE_W-1:0] = code;
         val[SY_STORE]      = is_store;
         val[SY_DSLOT]      = dslot;
      end else if (grant[G_HWX]) begin
         val           = hwx_syn;
         val[SY_DSLOT] = dslot;
      end
   end

   assign we       = grant[G_MMU] | grant[G_HWX];
   assign save_tgt = we & dslot;
endmodule

// File: rtl/exc_status.sv
module exc_status
   import exc_entry_pkg::*;
#(
   parameter int STAT_W = 16
) (
   input  logic [NEV-1:0]    grant,
   input  logic [STAT_W-1:0] cur,
   output logic [STAT_W-1:0] nxt
);
   always_comb begin
      nxt = cur;
      if (grant[G_IRQ]) nxt[ST_IE]  = 1'b0;
      if (grant[G_BRK]) nxt[ST_BIP] = 1'b1;
      if (grant[G_MMU] | grant[G_HWX]) nxt[ST_EIP] = 1'b1;
      // live mode bits move into their saved copies
      nxt[ST_UMS] = cur[ST_UM];
      nxt[ST_VMS] = cur[ST_VM];
      nxt[ST_UM]  = 1'b0;
      nxt[ST_VM]  = 1'b0;
   end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
   import exc_entry_pkg::*;
#(
   parameter int AW      = 32,
   parameter int STAT_W  = 16,
   parameter int ESR_W   = 16,
   parameter int OFS_IRQ = 'h10,
   parameter int OFS_BRK = 'h18,
   parameter int OFS_EXC = 'h20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              irq_req,
   input  logic              brk_req,
   input  logic              mmu_req,
   input  logic              mmu_miss,
   input  logic [1:0]        mmu_acc,
   input  logic [AW-1:0]     mmu_addr,
   input  logic              hwx_req,
   input  logic [ESR_W-1:0]  hwx_syn,
   input  logic              exc_support,
   input  logic [AW-1:0]     cur_pc,
   input  logic [STAT_W-1:0] cur_stat,
   input  logic              in_dslot,
   input  logic              in_imm,
   input  logic              in_bimm,
   input  logic [AW-1:0]     br_target,
   input  logic [AW-1:0]     vec_base,
   output logic              commit,
   output logic              busy,
   output logic [AW-1:0]     new_pc,
   output logic              link_we,
   output logic [4:0]        link_sel,
   output logic [AW-1:0]     link_val,
   output logic [STAT_W-1:0] stat_val,
   output logic              esr_we,
   output logic [ESR_W-1:0]  esr_val,
   output logic              ear_we,
   output logic [AW-1:0]     ear_val,
   output logic              btr_we,
   output logic [AW-1:0]     btr_val,
   output logic              iflag_clr,
   output logic              resv_clr
);
   initial begin
      if (AW < 8)           $fatal(1, "exc_entry: AW too small");
      if (STAT_W <= ST_VMS) $fatal(1, "exc_entry: STAT_W too small");
      if (ESR_W <= SY_DSLOT) $fatal(1, "exc_entry: ESR_W too small");
   end

   logic [NEV-1:0]    req;
   logic [NEV-1:0]    grant;
   logic              take;
   logic              irq_open;
   logic [AW-1:0]     c_target;
   logic [4:0]        c_lsel;
   logic [AW-1:0]     c_lval;
   logic [STAT_W-1:0] c_stat;
   logic              c_esr_we;
   logic [ESR_W-1:0]  c_esr;
   logic              c_save;

   assign irq_open = cur_stat[ST_IE] & ~cur_stat[ST_EIP] & ~cur_stat[ST_BIP]
                   & ~in_dslot & ~in_imm;

   assign req[G_MMU] = mmu_req;
   assign req[G_HWX] = hwx_req & exc_support;
   assign req[G_BRK] = brk_req;
   assign req[G_IRQ] = irq_req & irq_open;

   exc_arb #(.N(NEV)) u_arb (
      .req   (req),
      .grant (grant)
   );

   assign take = |grant;

   exc_link #(
      .AW(AW), .OFS_IRQ(OFS_IRQ), .OFS_BRK(OFS_BRK), .OFS_EXC(OFS_EXC)
   ) u_link (
      .grant    (grant),
      .pc       (cur_pc),
      .vec_base (vec_base),
      .dslot    (in_dslot),
      .imm      (in_imm),
      .bimm     (in_bimm),
      .target   (c_target),
      .lsel     (c_lsel),
      .lval     (c_lval)
   );

   exc_syndrome #(.ESR_W(ESR_W)) u_syn (
      .grant    (grant),
      .miss     (mmu_miss),
      .acc      (mmu_acc),
      .hwx_syn  (hwx_syn),
      .dslot    (in_dslot),
      .we       (c_esr_we),
      .val      (c_esr),
      .save_tgt (c_save)
   );

   exc_status #(.STAT_W(STAT_W)) u_stat (
      .grant (grant),
      .cur   (cur_stat),
      .nxt   (c_stat)
   );

   always_ff @(posedge clk) begin
      if (rst || !take) begin
         commit    <= 1'b0;
         new_pc    <= '0;
         link_we   <= 1'b0;
         link_sel  <= '0;
         link_val  <= '0;
         stat_val  <= '0;
         esr_we    <= 1'b0;
         esr_val   <= '0;
         ear_we    <= 1'b0;
         ear_val   <= '0;
         btr_we    <= 1'b0;
         btr_val   <= '0;
         iflag_clr <= 1'b0;
         resv_clr  <= 1'b0;
      end else begin
         commit    <= 1'b1;
         new_pc    <= c_target;
         link_we   <= 1'b1;
         link_sel  <= c_lsel;
         link_val  <= c_lval;
         stat_val  <= c_stat;
         esr_we    <= c_esr_we;
         esr_val   <= c_esr;
         ear_we    <= grant[G_MMU];
         ear_val   <= grant[G_MMU] ? mmu_addr : '0;
         btr_we    <= c_save;
         btr_val   <= c_save ? br_target : '0;
         iflag_clr <= 1'b1;
         resv_clr  <= 1'b1;
      end
   end

   // busy kept on its own flop from the request vector
   always_ff @(posedge clk) begin
      if (rst) busy <= 1'b0;
      else     busy <= |req;
   end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
   import exc_entry_pkg::*;
#(
   parameter int AW      = 32,
   parameter int STAT_W  = 16,
   parameter int ESR_W   = 16,
   parameter int OFS_IRQ = 'h10,
   parameter int OFS_BRK = 'h18,
   parameter int OFS_EXC = 'h20
) (
   input logic              clk,
   input logic              rst,
   input logic              irq_req,
   input logic              brk_req,
   input logic              mmu_req,
   input logic              hwx_req,
   input logic              exc_support,
   input logic [STAT_W-1:0] cur_stat,
   input logic              in_dslot,
   input logic              in_imm,
   input logic [AW-1:0]     vec_base,
   input logic              commit,
   input logic              busy,
   input logic [AW-1:0]     new_pc,
   input logic [4:0]        link_sel,
   input logic [STAT_W-1:0] stat_val,
   input logic              esr_we,
   input logic [ESR_W-1:0]  esr_val,
   input logic              ear_we,
   input logic              btr_we,
   input logic              iflag_clr,
   input logic              resv_clr
);
   logic [AW-1:0] ofs;
   assign ofs = (link_sel == LR_IRQ) ? AW'(OFS_IRQ) :
                (link_sel == LR_BRK) ? AW'(OFS_BRK) : AW'(OFS_EXC);

   assert_vector_R1: assert property (@(posedge clk) disable iff (rst)
      commit |-> new_pc == $past(vec_base) + ofs);

   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
      (commit && link_sel == LR_IRQ) |->
         ($past(cur_stat[ST_IE]) && !$past(cur_stat[ST_EIP]) && !$past(cur_stat[ST_BIP])
          && !$past(in_dslot) && !$past(in_imm)));

   assert_mode_save_R7: assert property (@(posedge clk) disable iff (rst)
      commit |-> (!stat_val[ST_UM] && !stat_val[ST_VM]
                  && stat_val[ST_UMS] == $past(cur_stat[ST_UM])
                  && stat_val[ST_VMS] == $past(cur_stat[ST_VM])));

   assert_busy_R13: assert property (@(posedge clk) disable iff (rst)
      busy == commit);

   assert_cause_R13: assert property (@(posedge clk) disable iff (rst)
      commit |-> $past(irq_req || brk_req || mmu_req || hwx_req));

   assert_dslot_R6: assert property (@(posedge clk) disable iff (rst)
      (commit && esr_we) |-> (esr_val[SY_DSLOT] == $past(in_dslot)
                              && btr_we == $past(in_dslot)));

   assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
      (iflag_clr == commit) && (resv_clr == commit));

   assert_ignore_R10: assert property (@(posedge clk) disable iff (rst)
      (commit && link_sel == LR_EXC && !ear_we) |-> $past(exc_support));

   assert_rank_R12: assert property (@(posedge clk) disable iff (rst)
      (commit && $past(mmu_req)) |-> ear_we);
endmodule

bind exc_entry exc_entry_chk #(
   .AW(AW), .STAT_W(STAT_W), .ESR_W(ESR_W),
   .OFS_IRQ(OFS_IRQ), .OFS_BRK(OFS_BRK), .OFS_EXC(OFS_EXC)
) u_chk (
   .clk(clk), .rst(rst), .irq_req(irq_req), .brk_req(brk_req),
   .mmu_req(mmu_req), .hwx_req(hwx_req), .exc_support(exc_support),
   .cur_stat(cur_stat), .in_dslot(in_dslot), .in_imm(in_imm),
   .vec_base(vec_base), .commit(commit), .busy(busy), .new_pc(new_pc),
   .link_sel(link_sel), .stat_val(stat_val), .esr_we(esr_we),
   .esr_val(esr_val), .ear_we(ear_we), .btr_we(btr_we),
   .iflag_clr(iflag_clr), .resv_clr(resv_clr)
);

// File: tb/exc_entry_test.sv
module exc_entry_test;
   localparam int AW = 32;
   localparam int SW = 16;
   localparam int EW = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic          irq_req = 0, brk_req = 0, mmu_req = 0, mmu_miss = 0, hwx_req = 0;
   logic [1:0]    mmu_acc = 0;
   logic [AW-1:0] mmu_addr = 0, cur_pc = 0, br_target = 0, vec_base = 0;
   logic [EW-1:0] hwx_syn = 0;
   logic          exc_support = 1, in_dslot = 0, in_imm = 0, in_bimm = 0;
   logic [SW-1:0] cur_stat = 0;

   logic          commit, busy, link_we, esr_we, ear_we, btr_we, iflag_clr, resv_clr;
   logic [AW-1:0] new_pc, link_val, ear_val, btr_val;
   logic [4:0]    link_sel;
   logic [SW-1:0] stat_val;
   logic [EW-1:0] esr_val;

   exc_entry uut (
      .clk(clk), .rst(rst), .irq_req(irq_req), .brk_req(brk_req),
      .mmu_req(mmu_req), .mmu_miss(mmu_miss), .mmu_acc(mmu_acc),
      .mmu_addr(mmu_addr), .hwx_req(hwx_req), .hwx_syn(hwx_syn),
      .exc_support(exc_support), .cur_pc(cur_pc), .cur_stat(cur_stat),
      .in_dslot(in_dslot), .in_imm(in_imm), .in_bimm(in_bimm),
      .br_target(br_target), .vec_base(vec_base),
      .commit(commit), .busy(busy), .new_pc(new_pc), .link_we(link_we),
      .link_sel(link_sel), .link_val(link_val), .stat_val(stat_val),
      .esr_we(esr_we), .esr_val(esr_val), .ear_we(ear_we), .ear_val(ear_val),
      .btr_we(btr_we), .btr_val(btr_val), .iflag_clr(iflag_clr),
      .resv_clr(resv_clr)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // expected outputs
   logic          x_commit, x_link_we, x_esr_we, x_ear_we, x_btr_we;
   logic [AW-1:0] x_pc, x_link, x_ear, x_btr;
   logic [4:0]    x_sel;
   logic [SW-1:0] x_stat;
   logic [EW-1:0] x_esr;

   task automatic cmp(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference of one entry decision
   task automatic predict();
      int kind;   // 0 none, 1 fault, 2 exception, 3 break, 4 interrupt
      logic ok_irq;
      ok_irq = cur_stat[0] && !cur_stat[1] && !cur_stat[2] && !in_dslot && !in_imm;
      if (mmu_req) kind = 1;
      else if (hwx_req && exc_support) kind = 2;
      else if (brk_req) kind = 3;
      else if (irq_req && ok_irq) kind = 4;
      else kind = 0;

      x_commit = (kind != 0); x_link_we = x_commit;
      x_pc = 0; x_link = 0; x_sel = 0; x_stat = 0; x_esr = 0; x_esr_we = 0;
      x_ear = 0; x_ear_we = 0; x_btr = 0; x_btr_we = 0;
      if (kind == 0) return;

      x_stat = cur_stat;
      case (kind)
         1, 2: x_stat[2] = 1'b1;
         3:    x_stat[1] = 1'b1;
         default: x_stat[0] = 1'b0;
      endcase
      x_stat[5] = cur_stat[4]; x_stat[7] = cur_stat[6];
      x_stat[4] = 1'b0;        x_stat[6] = 1'b0;

      case (kind)
         1: begin
            x_pc = vec_base + 32; x_sel = 17;
            if (in_dslot) x_link = in_bimm ? cur_pc - 8 : cur_pc - 4;
            else if (in_imm) x_link = cur_pc - 4;
            else x_link = cur_pc;
            x_esr_we = 1;
            x_esr = EW'(mmu_miss ? 18 : 16) + EW'(mmu_acc == 2'd0);
            x_esr[10] = (mmu_acc == 2'd2);
            x_esr[12] = in_dslot;
            x_ear_we = 1; x_ear = mmu_addr;
         end
         2: begin
            x_pc = vec_base + 32; x_sel = 17; x_link = cur_pc + 4;
            x_esr_we = 1; x_esr = hwx_syn; x_esr[12] = in_dslot;
         end
         3: begin x_pc = vec_base + 24; x_sel = 16; x_link = cur_pc; end
         default: begin x_pc = vec_base + 16; x_sel = 14; x_link = cur_pc; end
      endcase
      if ((kind == 1 || kind == 2) && in_dslot) begin
         x_btr_we = 1; x_btr = br_target;
      end
   endtask

   // one clock: inputs are set before the call, compare just after the edge
   task automatic step(input string tag);
      predict();
      @(posedge clk);
      #1;
      cmp(tag, "commit",   commit,    x_commit);
      cmp(tag, "busy",     busy,      x_commit);
      cmp(tag, "new_pc",   new_pc,    x_pc);
      cmp(tag, "link_we",  link_we,   x_link_we);
      cmp(tag, "link_sel", link_sel,  x_sel);
      cmp(tag, "link_val", link_val,  x_link);
      cmp(tag, "stat_val", stat_val,  x_stat);
      cmp(tag, "esr_we",   esr_we,    x_esr_we);
      cmp(tag, "esr_val",  esr_val,   x_esr);
      cmp(tag, "ear_we",   ear_we,    x_ear_we);
      cmp(tag, "ear_val",  ear_val,   x_ear);
      cmp(tag, "btr_we",   btr_we,    x_btr_we);
      cmp(tag, "btr_val",  btr_val,   x_btr);
      cmp(tag, "iflag_clr", iflag_clr, x_commit);
      cmp(tag, "resv_clr", resv_clr,  x_commit);
      @(negedge clk);
   endtask

   task automatic quiet();
      irq_req = 0; brk_req = 0; mmu_req = 0; hwx_req = 0;
      in_dslot = 0; in_imm = 0; in_bimm = 0;
   endtask

   initial begin
      vec_base = 32'h0000_8000; cur_pc = 32'h0000_1230;
      br_target = 32'h0000_4440; mmu_addr = 32'hDEAD_BEE0;
      hwx_syn = 16'h0005;
      repeat (3) @(negedge clk);
      // reset state, R13
      checks++;
      if (commit !== 1'b0 || busy !== 1'b0 || link_we !== 1'b0) begin
         failures++;
         $display("FAIL R13 reset commit=%0b busy=%0b expected 0", commit, busy);
      end
      rst = 0;
      step("R13");

      // R2, R7: interrupt with user mode on
      quiet(); cur_stat = 16'h0011; irq_req = 1; step("R2");
      quiet(); step("R13");
      // R9: interrupt refused under each blocking condition
      cur_stat = 16'h0010; irq_req = 1; step("R9");
      cur_stat = 16'h0005; irq_req = 1; step("R9");
      cur_stat = 16'h0003; irq_req = 1; step("R9");
      cur_stat = 16'h0001; irq_req = 1; in_dslot = 1; step("R9");
      quiet(); cur_stat = 16'h0001; irq_req = 1; in_imm = 1; step("R9");
      // R3, R7: break with translation on
      quiet(); cur_stat = 16'h0051; cur_pc = 32'h0000_2000; brk_req = 1; step("R3");
      // R4: hardware exception outside and inside a delay slot
      quiet(); hwx_req = 1; exc_support = 1; hwx_syn = 16'h1005; step("R4");
      quiet(); hwx_req = 1; in_dslot = 1; hwx_syn = 16'h0007; step("R6");
      // R10: exception ignored when not configured
      quiet(); exc_support = 0; hwx_req = 1; step("R10");
      quiet(); hwx_req = 1; brk_req = 1; step("R10");
      exc_support = 1;
      // R8: all syndrome codes and access types
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 4; a++) begin
            quiet(); mmu_req = 1; mmu_miss = m[0]; mmu_acc = a[1:0];
            mmu_addr = 32'h0100_0000 + 32'(m * 16 + a * 4);
            step("R8");
         end
      end
      // R5: link replay cases
      quiet(); cur_pc = 32'h0000_3010; mmu_req = 1; in_dslot = 1; in_bimm = 1; step("R5");
      quiet(); mmu_req = 1; in_dslot = 1; step("R5");
      quiet(); mmu_req = 1; in_imm = 1; step("R5");
      quiet(); mmu_req = 1; in_bimm = 1; step("R5");
      quiet(); mmu_req = 1; step("R5");
      // R12: ranking
      quiet(); cur_stat = 16'h0001; mmu_req = 1; hwx_req = 1; brk_req = 1; irq_req = 1; step("R12");
      quiet(); hwx_req = 1; brk_req = 1; irq_req = 1; step("R12");
      quiet(); brk_req = 1; irq_req = 1; step("R12");
      quiet(); irq_req = 1; vec_base = 32'h0000_0100; step("R1");
      // R11 and R13: strobes drop once requests stop
      quiet(); step("R11");
      step("R13");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule